// File: doc/BRIEF.md
# Reloading Interval Timer Channel

A single down-counting timer channel that produces a periodic interrupt pulse and a square-wave output. Software programs a period value, picks a few mode options and then fires a start trigger. The channel waits for the next count-clock enable (a one-cycle strobe from an external prescaler) and loads the period into its counter on that strobe. It then counts down on each later strobe. On the strobe that finds the counter at zero it reloads the period, raises an interrupt pulse and flips its square-wave flop. A channel with period P therefore fires once every P+1 strobes.

A stop trigger freezes the counter and the output where they are. Mode settings are locked while the channel runs. The period may be rewritten at any time, and the new value is picked up at the next reload. The output pin is driven either directly by a software level bit or by the toggle logic, depending on an output-enable bit.

The register port is a simple single-cycle write strobe with an address. Read data is returned combinationally for the current address.

Top module: `itv_chan`

## Requirements
- R1: Writing a word with bit0=1 and bit1=0 to the control register (address 2) sets the running status (bit2 of a control-register read) on the next clock. Bits 0 and 1 of a control-register read are always 0.
- R2: On the first count strobe after a start, the counter (read at address 4) is loaded with the period register (address 0). It is not decremented on that strobe.
- R3: If mode bit0 (mode register, address 1) is 1, the first strobe after a start also raises the interrupt and toggles the output. If mode bit0 is 0, that strobe does neither.
- R4: While running, every later strobe decrements the counter. A strobe that finds the counter at 0 reloads the period instead, and counting continues.
- R5: The interrupt is high for exactly the cycles in which a strobe finds a running, non-first-strobe counter at 0 (plus the optional start event of R3). For a period P, interrupts are spaced P+1 strobes apart.
- R6: When output enable is 1, each interrupt flips the output flop. The pin equals the flop, inverted if mode bit1 is 1.
- R7: A control write with bit1=1 clears the running status on the next clock. After that the counter keeps its value and no interrupt occurs on later strobes.
- R8: Stopping does not alter the output pin. It keeps its level until software writes a register.
- R9: A period written while running takes effect at the next reload and does not disturb the current count.
- R10: Writes to the mode register are ignored while running and accepted while stopped.
- R11: A write to the output register (address 3) with bit1=0 clears output enable and loads bit0 into the output flop, so the pin follows it directly. A write with bit1=1 sets output enable and leaves the flop unchanged. A read of address 3 returns the flop in bit0 and output enable in bit1.
- R12: When bit0 and bit1 of a control write are both 1, stop wins. A start while running re-arms the channel, so the next strobe reloads the period.
- R13: After reset the counter, the period, the mode and the running status are 0, the interrupt is low and the pin is at its reset level (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | One-cycle count strobe from the prescaler |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| irq | output | 1 | Interrupt pulse, aligned to the strobe that caused it |
| tmr_out | output | 1 | Square-wave / software-level output pin |
| running | output | 1 | Channel enable status |

## Verification
The bench targets the off-by-one spacing between interrupts. A design that reloads on reaching zero, rather than on the strobe after it, fires every P strobes instead of P+1, and the scoreboard's expected cycles drift. It also targets the start strobe. A design that decrements on the first strobe, or that raises an interrupt there with mode bit0 clear, leaves a wrong count or produces an unexpected interrupt. Further cases are start and stop written together, a restart while running, a period change mid-count, and mode writes while running. A wrong design there keeps running, keeps the old count, reloads early or changes its polarity under the counter.

// File: rtl/itv_pkg.sv
`timescale 1ns/1ps
package itv_pkg;
   // register addresses
   localparam int unsigned REG_PERIOD = 0;
   localparam int unsigned REG_MODE   = 1;
   localparam int unsigned REG_CTRL   = 2;
   localparam int unsigned REG_OUT    = 3;
   localparam int unsigned REG_COUNT  = 4;
   localparam int unsigned MIN_ADDR_W = 3;

   // bit positions inside registers
   localparam int unsigned CTRL_START = 0;
   localparam int unsigned CTRL_STOP  = 1;
   localparam int unsigned CTRL_RUN   = 2;
   localparam int unsigned OUT_LVL    = 0;
   localparam int unsigned OUT_EN     = 1;

   typedef struct packed {
      logic out_inv;    // bit1: invert pin while toggling
      logic start_evt;  // bit0: interrupt/toggle at start strobe
   } mode_t;
endpackage

// File: rtl/itv_regs.sv
`timescale 1ns/1ps
module itv_regs
   import itv_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              running,
   input  logic [CNT_W-1:0]  cnt_val,
   input  logic              out_q,
   output logic [CNT_W-1:0]  period_q,
   output mode_t             mode_q,
   output logic              out_en_q,
   output logic              start_p,
   output logic              stop_p,
   output logic              lvl_load,
   output logic              lvl_val,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam logic [ADDR_W-1:0] A_PERIOD = ADDR_W'(REG_PERIOD);
   localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(REG_MODE);
   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(REG_CTRL);
   localparam logic [ADDR_W-1:0] A_OUT    = ADDR_W'(REG_OUT);
   localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(REG_COUNT);

   logic wr_period, wr_mode, wr_ctrl, wr_out;

   assign wr_period = bus_wr && (bus_addr == A_PERIOD);
   assign wr_mode   = bus_wr && (bus_addr == A_MODE);
   assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
   assign wr_out    = bus_wr && (bus_addr == A_OUT);

   // trigger bits are never stored, so they read back as zero
   assign stop_p   = wr_ctrl && bus_wdata[CTRL_STOP];
   assign start_p  = wr_ctrl && bus_wdata[CTRL_START] && !bus_wdata[CTRL_STOP];
   assign lvl_load = wr_out && !bus_wdata[OUT_EN];
   assign lvl_val  = bus_wdata[OUT_LVL];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q <= '0;
         mode_q   <= '0;
         out_en_q <= 1'b0;
      end else begin
         if (wr_period) begin
            period_q <= bus_wdata[CNT_W-1:0];
         end
         if (wr_mode && !running) begin
            mode_q <= mode_t'(bus_wdata[1:0]);
         end
         if (wr_out) begin
            out_en_q <= bus_wdata[OUT_EN];
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_PERIOD: bus_rdata[CNT_W-1:0] = period_q;
         A_MODE:   bus_rdata[1:0]       = mode_q;
         A_CTRL:   bus_rdata[CTRL_RUN]  = running;
         A_OUT: begin
            bus_rdata[OUT_LVL] = out_q;
            bus_rdata[OUT_EN]  = out_en_q;
         end
         A_COUNT:  bus_rdata[CNT_W-1:0] = cnt_val;
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/itv_core.sv
`timescale 1ns/1ps
module itv_core #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_tick,
   input  logic             start_p,
   input  logic             stop_p,
   input  logic [CNT_W-1:0] period_q,
   input  logic             start_evt,
   output logic             run_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic             evt
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic arm_q;
   logic step;
   logic at_zero;

   assign step    = run_q && cnt_tick;
   assign at_zero = (cnt_q == '0);
   assign evt     = step && (arm_q ? start_evt : at_zero);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         arm_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         if (step) begin
            cnt_q <= (arm_q || at_zero) ? period_q : (cnt_q - ONE);
            arm_q <= 1'b0;
         end
         if (stop_p) begin
            run_q <= 1'b0;
         end else if (start_p) begin
            run_q <= 1'b1;
            arm_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/itv_outgen.sv
`timescale 1ns/1ps
module itv_outgen #(
   parameter bit HAS_INVERT = 1'b1,
   parameter bit OUT_INIT   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic out_en,
   input  logic lvl_load,
   input  logic lvl_val,
   input  logic invert,
   output logic out_q,
   output logic tmr_out
);
   logic pol;

   generate
      if (HAS_INVERT) begin : g_inv
         assign pol = invert && out_en;
      end else begin : g_noinv
         assign pol = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= OUT_INIT;
      end else if (lvl_load) begin
         out_q <= lvl_val;
      end else if (evt && out_en) begin
         out_q <= !out_q;
      end
   end

   assign tmr_out = out_q ^ pol;
endmodule

// File: rtl/itv_chan.sv
`timescale 1ns/1ps
module itv_chan
   import itv_pkg::*;
#(
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned ADDR_W     = 3,
   parameter bit          HAS_INVERT = 1'b1,
   parameter bit          OUT_INIT   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_tick,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              tmr_out,
   output logic              running
);
   generate
      if (DATA_W < CNT_W) begin : g_bad_data
         $error("itv_chan: DATA_W must hold the whole counter");
      end
      if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
         $error("itv_chan: ADDR_W too narrow for the register map");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("itv_chan: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] period_q;
   logic [CNT_W-1:0] cnt_val;
   mode_t            mode_q;
   logic             out_en_q, start_p, stop_p, lvl_load, lvl_val;
   logic             out_q, evt;

   itv_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .running  (running),
      .cnt_val  (cnt_val),
      .out_q    (out_q),
      .period_q (period_q),
      .mode_q   (mode_q),
      .out_en_q (out_en_q),
      .start_p  (start_p),
      .stop_p   (stop_p),
      .lvl_load (lvl_load),
      .lvl_val  (lvl_val),
      .bus_rdata(bus_rdata)
   );

   itv_core #(.CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt_tick (cnt_tick),
      .start_p  (start_p),
      .stop_p   (stop_p),
      .period_q (period_q),
      .start_evt(mode_q.start_evt),
      .run_q    (running),
      .cnt_q    (cnt_val),
      .evt      (evt)
   );

   itv_outgen #(.HAS_INVERT(HAS_INVERT), .OUT_INIT(OUT_INIT)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt),
      .out_en  (out_en_q),
      .lvl_load(lvl_load),
      .lvl_val (lvl_val),
      .invert  (mode_q.out_inv),
      .out_q   (out_q),
      .tmr_out (tmr_out)
   );

   assign irq = evt;
endmodule

// File: rtl/itv_chk.sv
`timescale 1ns/1ps
module itv_chk
   import itv_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cnt_tick,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [1:0]        low_wdata,
   input logic              irq,
   input logic              tmr_out,
   input logic              running,
   input logic [CNT_W-1:0]  cnt_val,
   input logic [CNT_W-1:0]  period_q,
   input logic [1:0]        mode_q
);
   logic ctrl_wr, mode_wr;
   assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(REG_CTRL));
   assign mode_wr = bus_wr && (bus_addr == ADDR_W'(REG_MODE));

   AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr && low_wdata[0] && !low_wdata[1] |=> running); // R1
   AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      running && cnt_tick && (cnt_val == '0) |=> cnt_val == $past(period_q)); // R4
   AST_IRQ_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> cnt_tick && running); // R5
   AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      !running |=> $stable(cnt_val)); // R7
   AST_PIN_HELD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      !running && !bus_wr |=> $stable(tmr_out)); // R8
   AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      running && mode_wr |=> $stable(mode_q)); // R10
   AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr && low_wdata[1] |=> !running); // R12
endmodule

bind itv_chan itv_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cnt_tick (cnt_tick),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .low_wdata(bus_wdata[1:0]),
   .irq      (irq),
   .tmr_out  (tmr_out),
   .running  (running),
   .cnt_val  (cnt_val),
   .period_q (period_q),
   .mode_q   (mode_q)
);

// File: tb/sim_itv_chan.sv
`timescale 1ns/1ps
module sim_itv_chan;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        wr = 1'b0;
   logic [2:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        irq, tmr_out, running;

   int n_cmp = 0;
   int n_mis = 0;
   int win = 0;
   bit sb_on = 1'b0;
   int expq[$];

   itv_chan u0 (
      .clk(clk), .rst_n(rst_n), .cnt_tick(tick), .bus_wr(wr),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
      .irq(irq), .tmr_out(tmr_out), .running(running)
   );

   always #2.5 clk = ~clk;

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_mis++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk); wr = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk); addr = a; #1 d = rdata;
   endtask

   task automatic pulse_tick();
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
   endtask

   // monitor: pops expected interrupt windows and compares
   initial begin
      forever begin
         @(negedge clk); #1;
         win++;
         if (sb_on && irq) begin
            if (expq.size() == 0) begin
               check("R3/R5 unexpected irq window", 16'(win), 16'hFFFF);
            end else begin
               check("R5 irq window", 16'(win), 16'(expq.pop_front()));
            end
         end
      end
   end

   // driver: free-running strobes, expected interrupts queued up front
   task automatic run_sb(input int p, input bit md0, input int nk);
      int ws;
      logic [15:0] c1, c2;
      logic        pin;
      wr_reg(3'd1, 16'(md0));
      wr_reg(3'd0, 16'(p));
      wr_reg(3'd3, 16'h0000);
      wr_reg(3'd3, 16'h0002);
      sb_on = 1'b1;
      @(negedge clk); tick = 1'b1;
      @(negedge clk); wr = 1'b1; addr = 3'd2; wdata = 16'h0001;
      #2 ws = win;
      if (md0) expq.push_back(ws + 1);
      for (int k = 1; k <= nk; k++) expq.push_back(ws + 1 + (p + 1) * k);
      @(negedge clk); wr = 1'b0;
      repeat ((p + 1) * nk + 1) @(negedge clk);
      wr_reg(3'd2, 16'h0002);
      tick = 1'b0;
      check("R5 all expected irqs seen", 16'(expq.size()), 16'd0);
      expq.delete();
      check("R6 pin after toggles", {15'd0, tmr_out}, 16'((int'(md0) + nk) % 2));
      check("R7 stopped", {15'd0, running}, 16'd0);
      rd_reg(3'd4, c1);
      pin = tmr_out;
      pulse_tick(); pulse_tick(); pulse_tick();
      rd_reg(3'd4, c2);
      check("R7 count held after stop", c2, c1);
      check("R8 pin held after stop", {15'd0, tmr_out}, {15'd0, pin});
      sb_on = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_mis++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
   end

   initial begin
      logic [15:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R13 reset state
      rd_reg(3'd4, d); check("R13 count at reset", d, 16'd0);
      rd_reg(3'd0, d); check("R13 period at reset", d, 16'd0);
      rd_reg(3'd2, d); check("R13 status at reset", d, 16'd0);
      rd_reg(3'd1, d); check("R13 mode at reset", d, 16'd0);
      check("R13 irq at reset", {15'd0, irq}, 16'd0);
      check("R13 pin at reset", {15'd0, tmr_out}, 16'd0);

      // R1 / R2 / R4
      wr_reg(3'd0, 16'd5);
      wr_reg(3'd2, 16'h0001);
      rd_reg(3'd2, d); check("R1 running, triggers read 0", d, 16'h0004);
      pulse_tick();
      rd_reg(3'd4, d); check("R2 first strobe loads period", d, 16'd5);
      pulse_tick();
      rd_reg(3'd4, d); check("R4 decrement", d, 16'd4);

      // R10 mode locked while running
      wr_reg(3'd1, 16'h0003);
      rd_reg(3'd1, d); check("R10 mode write ignored while running", d, 16'd0);

      // R9 period change while running
      wr_reg(3'd0, 16'd2);
      rd_reg(3'd4, d); check("R9 count undisturbed", d, 16'd4);
      repeat (4) pulse_tick();
      rd_reg(3'd4, d); check("R4 reached zero", d, 16'd0);
      @(negedge clk); tick = 1'b1;
      #1 check("R5 irq on zero strobe", {15'd0, irq}, 16'd1);
      @(negedge clk); tick = 1'b0;
      #1 check("R5 irq one cycle", {15'd0, irq}, 16'd0);
      rd_reg(3'd4, d); check("R9 new period at reload", d, 16'd2);

      // R12 restart while running
      pulse_tick();
      wr_reg(3'd0, 16'd9);
      wr_reg(3'd2, 16'h0001);
      @(negedge clk); tick = 1'b1;
      #1 check("R3 no start irq with mode bit0 clear", {15'd0, irq}, 16'd0);
      @(negedge clk); tick = 1'b0;
      rd_reg(3'd4, d); check("R12 restart reloads", d, 16'd9);

      // R12 stop wins over start
      wr_reg(3'd2, 16'h0003);
      rd_reg(3'd2, d); check("R12 stop priority", d, 16'd0);
      pulse_tick();
      rd_reg(3'd4, d); check("R7 count frozen", d, 16'd9);

      // R11 software level
      wr_reg(3'd3, 16'h0001);
      check("R11 pin follows level 1", {15'd0, tmr_out}, 16'd1);
      rd_reg(3'd3, d); check("R11 output reg read", d, 16'h0001);
      wr_reg(3'd3, 16'h0000);
      check("R11 pin follows level 0", {15'd0, tmr_out}, 16'd0);
      wr_reg(3'd3, 16'h0003);
      check("R11 level ignored when enabled", {15'd0, tmr_out}, 16'd0);

      // R6 inversion, R10 accepted while stopped
      wr_reg(3'd1, 16'h0002);
      rd_reg(3'd1, d); check("R10 mode write accepted when stopped", d, 16'h0002);
      check("R6 inverted pin", {15'd0, tmr_out}, 16'd1);
      wr_reg(3'd1, 16'h0000);
      check("R6 pin not inverted", {15'd0, tmr_out}, 16'd0);

      // scoreboard runs: R3 R5 R6
      run_sb(3, 1'b0, 4);
      run_sb(2, 1'b1, 5);
      run_sb(6, 1'b1, 3);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
   end
endmodule